// File: doc/BRIEF.md
# NAND Flash Host Controller

This block connects a register-mapped processor bus to a raw NAND flash device. Software programs strobe widths, a data-width select and a page-size select in a control register. It then writes command bytes, address bytes and data bytes into dedicated registers. Each such write becomes one entry in a small outgoing queue. A strobe sequencer takes entries from the queue one at a time and plays them out on the flash pins: chip enable, write strobe, read strobe, the command latch and address latch lines, and the data bus.

A byte is read from the flash in two steps. A write of any value to the read-request register queues a read cycle. When that cycle has captured the bus, a ready flag is raised and the byte is held in the read-data register. Sticky event flags record several events: the device becoming ready, an entry dropped by a full queue, the queue leaving its full state, read data arriving, and a data write finishing with nothing left queued. Each flag is cleared by writing 1 to its bit. A mask selects which flags drive the interrupt line. The ready/busy pin passes through a two-flop synchroniser before software sees it.

Top module: `nand_host`

## Requirements
- R1: After reset, CE#, WE# and RE# are high, CLE, ALE, the data-bus enable and irq are low, and every register reads 0 except status, which reads 0x10 while the ready/busy pin is low.
- R2: A write to offset 4 (command) queues a cycle that drives CLE high and ALE low. During that cycle WE# is low for exactly (CTRL[3:0]+1) clocks, followed by one hold clock. CE# is low for the whole cycle. When entries are waiting, consecutive cycles are separated by one idle clock.
- R3: A write to offset 5 (address) queues a cycle in the same form with ALE high and CLE low. Command and address bytes drive only bits 7:0 of the bus, and bits 15:8 are 0.
- R4: A write to offset 6 (data) queues a cycle with CLE and ALE both low and the bus enabled. The full 16 bits are driven when CTRL[8] was 1 at the time of the write, and only bits 7:0 otherwise.
- R5: A write to offset 7 (read request) queues a read cycle. RE# is low for (CTRL[7:4]+1) clocks and the bus is not driven. On the clock edge that raises RE#, the bus is captured into the read-data register (offset 8), with bits 15:8 cleared when CTRL[8] is 0, and flag bit 3 is set.
- R6: The queue holds 4 entries and plays them out in write order. Status bit 1 means full and bit 4 means empty. A queue write while the queue is full is dropped and sets flag bit 1, even if an entry leaves the queue in the same clock.
- R7: Flag bit 2 is set when an entry leaves a full queue.
- R8: Flag bit 4 is set when a data-write cycle ends while the queue is empty.
- R9: Status bit 0 follows the ready/busy pin two clocks late. Flag bit 0 is set on each rising edge of that synchronised copy.
- R10: Flags (offset 2) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A flag that is set and cleared in the same clock stays set.
- R11: irq is high exactly when some flag bit and its mask bit (offset 3, bits 4:0) are both 1. The mask resets to 0.
- R12: The control register (offset 0) keeps bits 9:0 of the value written and reads back 0 in bits 15:10.
- R13: Status bit 2 is 1 while a data-write cycle is queued or in progress. Status bit 3 is 1 while a read cycle is queued or in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 16 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin, high when ready |
| irq | output | 1 | Masked interrupt request |

## Verification
A queue pointer or count that goes wrong changes which byte appears on the bus, and which latch line is high, in the very next cycle the sequencer starts. It also makes the full and empty status bits disagree with the count of writes accepted. A sequencer counter that is off by one makes a strobe one clock too short or too long. A wrong capture edge leaves a neighbouring bus value in the read-data register, and this shows as soon as the ready flag rises. Flag and mask errors show at irq and at the flag register in the clock after the event, so comparing every pin and the addressed register on every clock exposes them within one cycle.

// File: rtl/nand_host_pkg.sv
`timescale 1ns/1ps
package nand_host_pkg;
  parameter int DQ_W  = 16;
  parameter int NFLAG = 5;

  typedef enum logic [1:0] {CY_CMD = 2'd0, CY_ADDR = 2'd1, CY_DWR = 2'd2, CY_DRD = 2'd3} cyc_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_STROBE = 2'd1, PH_HOLD = 2'd2} phase_t;

  typedef struct packed {
    cyc_t            kind;
    logic [DQ_W-1:0] data;
  } entry_t;

  localparam logic [3:0] OFS_CTRL  = 4'd0;
  localparam logic [3:0] OFS_STAT  = 4'd1;
  localparam logic [3:0] OFS_FLAG  = 4'd2;
  localparam logic [3:0] OFS_MASK  = 4'd3;
  localparam logic [3:0] OFS_CMD   = 4'd4;
  localparam logic [3:0] OFS_ADDR  = 4'd5;
  localparam logic [3:0] OFS_DWR   = 4'd6;
  localparam logic [3:0] OFS_DRD   = 4'd7;
  localparam logic [3:0] OFS_RDATA = 4'd8;

  // keep the low byte only unless the wide bus is selected
  function automatic logic [DQ_W-1:0] fit_bus(input logic [DQ_W-1:0] v, input logic wide);
    fit_bus = wide ? v : {{(DQ_W-8){1'b0}}, v[7:0]};
  endfunction

  // strobe low time minus one, picked by cycle kind
  function automatic logic [3:0] strobe_len(input cyc_t k, input logic [3:0] wr_d, input logic [3:0] rd_d);
    strobe_len = (k == CY_DRD) ? rd_d : wr_d;
  endfunction
endpackage

// File: rtl/nand_host_fifo.sv
`timescale 1ns/1ps
module nand_host_fifo
  import nand_host_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  entry_t        push_ent,
  input  logic          pop,
  output entry_t        head,
  output logic [CW-1:0] count,
  output logic          accepted,
  output logic          has_dwr,
  output logic          has_drd
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  entry_t        mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          pop_ok;

  assign accepted = push && (count != FULL_CNT);
  assign pop_ok   = pop && (count != '0);
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (accepted) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (accepted) wp <= wp + 1'b1;
      if (pop_ok) rp <= rp + 1'b1;
      case ({accepted, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    logic [PW-1:0] off;
    has_dwr = 1'b0;
    has_drd = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      off = PW'(i) - rp;
      if (CW'(off) < count) begin
        if (mem[i].kind == CY_DWR) has_dwr = 1'b1;
        if (mem[i].kind == CY_DRD) has_drd = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_host_seq.sv
`timescale 1ns/1ps
module nand_host_seq
  import nand_host_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  entry_t          next_ent,
  input  logic [3:0]      wr_dly,
  input  logic [3:0]      rd_dly,
  output logic            idle,
  output cyc_t            cur_kind,
  output logic            cap_evt,
  output logic            done_evt,
  output logic            ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_out
);
  phase_t     ph;
  logic [3:0] cnt;
  entry_t     cur;
  logic       busy, strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
      cur <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_STROBE;
          cur <= next_ent;
          cnt <= strobe_len(next_ent.kind, wr_dly, rd_dly);
        end
        PH_STROBE: if (cnt == 4'd0) ph <= PH_HOLD;
                   else cnt <= cnt - 4'd1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign strobe   = (ph == PH_STROBE);
  assign idle     = !busy;
  assign cur_kind = cur.kind;
  assign cap_evt  = strobe && (cnt == 4'd0) && (cur.kind == CY_DRD);
  assign done_evt = (ph == PH_HOLD);
  assign ce_n     = !busy;
  assign cle      = busy && (cur.kind == CY_CMD);
  assign ale      = busy && (cur.kind == CY_ADDR);
  assign we_n     = !(strobe && (cur.kind != CY_DRD));
  assign re_n     = !(strobe && (cur.kind == CY_DRD));
  assign dq_oe    = busy && (cur.kind != CY_DRD);
  assign dq_out   = dq_oe ? cur.data : '0;
endmodule

// File: rtl/nand_host_irq.sv
`timescale 1ns/1ps
module nand_host_irq
  import nand_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rb_pin,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic [NFLAG-1:0] mask,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             nb_status,
  output logic             nb_rise
);
  logic rb_s1, rb_s2, rb_s3;
  logic [NFLAG-1:0] set_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1 <= 1'b0;
      rb_s2 <= 1'b0;
      rb_s3 <= 1'b0;
      flags <= '0;
    end else begin
      rb_s1 <= rb_pin;
      rb_s2 <= rb_s1;
      rb_s3 <= rb_s2;
      flags <= (flags & ~clr_vec) | set_all;
    end
  end

  assign nb_status = rb_s2;
  assign nb_rise   = rb_s2 && !rb_s3;
  assign set_all   = set_vec | {{(NFLAG-1){1'b0}}, nb_rise};
  assign irq       = |(flags & mask);
endmodule

// File: rtl/nand_host.sv
`timescale 1ns/1ps
module nand_host
  import nand_host_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DQ_W-1:0] reg_wdata,
  output logic [DQ_W-1:0] reg_rdata,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [DQ_W-1:0] nand_dq_out,
  output logic            nand_dq_oe,
  input  logic [DQ_W-1:0] nand_dq_in,
  input  logic            nand_rb,
  output logic            irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int CTRL_W = 10;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CTRL_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  mask_q, flags_q, set_vec, clr_vec;
  logic [DQ_W-1:0]   rdata_q;
  logic [3:0]        ofs;
  logic              wide;

  logic          push_req, accepted, ovf_evt, pop, edge_evt, wdone_evt;
  entry_t        push_ent, head;
  logic [CW-1:0] count;
  logic          has_dwr, has_drd;

  logic seq_idle, cap_evt, done_evt, nb_status, nb_rise;
  cyc_t cur_kind;
  logic wr_pend, rd_pend;
  logic [NFLAG-1:0] status;

  assign ofs  = 4'(reg_addr);
  assign wide = ctrl_q[8];

  // queue write decode
  always_comb begin
    push_req = reg_wr && (ofs >= OFS_CMD) && (ofs <= OFS_DRD);
    push_ent = '0;
    case (ofs)
      OFS_CMD:  begin push_ent.kind = CY_CMD;  push_ent.data = fit_bus(reg_wdata, 1'b0); end
      OFS_ADDR: begin push_ent.kind = CY_ADDR; push_ent.data = fit_bus(reg_wdata, 1'b0); end
      OFS_DWR:  begin push_ent.kind = CY_DWR;  push_ent.data = fit_bus(reg_wdata, wide); end
      default:  begin push_ent.kind = CY_DRD;  push_ent.data = '0; end
    endcase
  end

  nand_host_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req), .push_ent(push_ent), .pop(pop),
    .head(head), .count(count), .accepted(accepted), .has_dwr(has_dwr), .has_drd(has_drd)
  );

  assign pop = seq_idle && (count != '0);

  nand_host_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(pop), .next_ent(head),
    .wr_dly(ctrl_q[3:0]), .rd_dly(ctrl_q[7:4]),
    .idle(seq_idle), .cur_kind(cur_kind), .cap_evt(cap_evt), .done_evt(done_evt),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_oe(nand_dq_oe), .dq_out(nand_dq_out)
  );

  assign ovf_evt   = push_req && !accepted;
  assign edge_evt  = pop && (count == FULL_CNT);
  assign wdone_evt = done_evt && (cur_kind == CY_DWR) && (count == '0);
  assign set_vec   = {wdone_evt, cap_evt, edge_evt, ovf_evt, 1'b0};
  assign clr_vec   = (reg_wr && ofs == OFS_FLAG) ? reg_wdata[NFLAG-1:0] : '0;

  nand_host_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rb_pin(nand_rb), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask(mask_q), .flags(flags_q), .irq(irq), .nb_status(nb_status), .nb_rise(nb_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_wr && ofs == OFS_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_wr && ofs == OFS_MASK) mask_q <= reg_wdata[NFLAG-1:0];
      if (cap_evt) rdata_q <= fit_bus(nand_dq_in, wide);
    end
  end

  assign wr_pend = has_dwr || (!seq_idle && cur_kind == CY_DWR);
  assign rd_pend = has_drd || (!seq_idle && cur_kind == CY_DRD);
  assign status  = {count == '0, rd_pend, wr_pend, count == FULL_CNT, nb_status};

  always_comb begin
    case (ofs)
      OFS_CTRL:  reg_rdata = DQ_W'(ctrl_q);
      OFS_STAT:  reg_rdata = DQ_W'(status);
      OFS_FLAG:  reg_rdata = DQ_W'(flags_q);
      OFS_MASK:  reg_rdata = DQ_W'(mask_q);
      OFS_RDATA: reg_rdata = rdata_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nand_host_chk.sv
`timescale 1ns/1ps
module nand_host_chk
  import nand_host_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             we_n,
  input logic             re_n,
  input logic             cle,
  input logic             ale,
  input logic             ovf_evt,
  input logic             cap_evt,
  input logic             nb_rise,
  input logic [CW-1:0]    count,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] mask,
  input logic             irq
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  p_ce_strobe_r2:  assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !re_n) |-> !ce_n);
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> flags[1]);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL_CNT);
  p_ready_flag_r5: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |=> flags[3]);
  p_nb_flag_r9:    assert property (@(posedge clk) disable iff (!rst_n) nb_rise |=> flags[0]);
  p_irq_mask_r11:  assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> (mask != '0));
endmodule

bind nand_host nand_host_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .we_n(nand_we_n), .re_n(nand_re_n),
  .cle(nand_cle), .ale(nand_ale), .ovf_evt(ovf_evt), .cap_evt(cap_evt), .nb_rise(nb_rise),
  .count(count), .flags(flags_q), .mask(mask_q), .irq(irq)
);

// File: tb/tb_nand_host.sv
`timescale 1ns/1ps
module tb_nand_host;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd1;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in = 16'h1234;
  logic        nand_rb = 1'b0;

  nand_host #(.DEPTH(DEPTH), .AW(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [3:0] watch = 4'd1;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int q[$];
  int m_ctrl = 0, m_mask = 0, m_flags = 0, m_rdata = 0;
  int m_ph = 0, m_cnt = 0, m_kind = 0, m_data = 0;
  bit m_rb1 = 0, m_rb2 = 0, m_rb3 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_ctrl = 0; m_mask = 0; m_flags = 0; m_rdata = 0;
      m_ph = 0; m_cnt = 0; m_kind = 0; m_data = 0;
      m_rb1 = 0; m_rb2 = 0; m_rb3 = 0;
    end else begin
      int osz, setv, clr, e, a;
      bit wide;
      osz = q.size();
      setv = 0; clr = 0;
      wide = m_ctrl[8];
      a = int'(reg_addr);
      if (m_ph == 0) begin
        if (osz > 0) begin
          e = q.pop_front();
          if (osz == DEPTH) setv |= 4;
          m_kind = e >> 16; m_data = e & 16'hffff;
          m_cnt = (m_kind == 3) ? ((m_ctrl >> 4) & 15) : (m_ctrl & 15);
          m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (m_cnt == 0) begin
          m_ph = 2;
          if (m_kind == 3) begin
            m_rdata = wide ? int'(nand_dq_in) : int'(nand_dq_in[7:0]);
            setv |= 8;
          end
        end else m_cnt--;
      end else begin
        m_ph = 0;
        if (m_kind == 2 && osz == 0) setv |= 16;
      end
      if (reg_wr && a >= 4 && a <= 7) begin
        if (osz == DEPTH) setv |= 2;
        else if (a == 4) q.push_back((0 << 16) | int'(reg_wdata[7:0]));
        else if (a == 5) q.push_back((1 << 16) | int'(reg_wdata[7:0]));
        else if (a == 6) q.push_back((2 << 16) | (wide ? int'(reg_wdata) : int'(reg_wdata[7:0])));
        else q.push_back(3 << 16);
      end
      if (reg_wr && a == 0) m_ctrl = int'(reg_wdata) & 16'h3ff;
      if (reg_wr && a == 3) m_mask = int'(reg_wdata) & 31;
      if (reg_wr && a == 2) clr = int'(reg_wdata) & 31;
      if (m_rb2 && !m_rb3) setv |= 1;
      m_flags = (m_flags & ~clr) | setv;
      m_rb3 = m_rb2; m_rb2 = m_rb1; m_rb1 = nand_rb;
    end
  end

  function automatic bit q_has(int k);
    foreach (q[i]) if ((q[i] >> 16) == k) return 1;
    return 0;
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit busy, strb;
      int oe, st;
      busy = (m_ph != 0);
      strb = (m_ph == 1);
      oe = (busy && m_kind != 3) ? 1 : 0;
      chk("R2 ce_n", nand_ce_n, !busy);
      chk("R2 we_n", nand_we_n, !(strb && m_kind != 3));
      chk("R2 cle", nand_cle, busy && m_kind == 0);
      chk("R3 ale", nand_ale, busy && m_kind == 1);
      chk("R5 re_n", nand_re_n, !(strb && m_kind == 3));
      chk("R4 dq_oe", nand_dq_oe, oe);
      chk("R4 dq_out", nand_dq_out, oe ? m_data : 0);
      chk("R11 irq", irq, (m_flags & m_mask) != 0);
      case (reg_addr)
        4'd0: chk("R12 ctrl", reg_rdata, m_ctrl);
        4'd1: begin
          st = int'(reg_rdata);
          chk("R9 status.ready", st & 1, m_rb2);
          chk("R6 status.full", (st >> 1) & 1, q.size() == DEPTH);
          chk("R13 status.wpend", (st >> 2) & 1, q_has(2) || (busy && m_kind == 2));
          chk("R13 status.rpend", (st >> 3) & 1, q_has(3) || (busy && m_kind == 3));
          chk("R6 status.empty", (st >> 4) & 1, q.size() == 0);
          chk("R6 status.upper", st >> 5, 0);
        end
        4'd2: begin
          st = int'(reg_rdata);
          chk("R9 R10 flag0", st & 1, m_flags & 1);
          chk("R6 R10 flag1", (st >> 1) & 1, (m_flags >> 1) & 1);
          chk("R7 R10 flag2", (st >> 2) & 1, (m_flags >> 2) & 1);
          chk("R5 R10 flag3", (st >> 3) & 1, (m_flags >> 3) & 1);
          chk("R8 R10 flag4", (st >> 4) & 1, (m_flags >> 4) & 1);
        end
        4'd3: chk("R11 mask", reg_rdata, m_mask);
        4'd8: chk("R5 rdata", reg_rdata, m_rdata);
        default: chk("R1 unmapped", reg_rdata, 0);
      endcase
    end
  end

  always @(negedge clk) #2 nand_dq_in <= nand_dq_in + 16'h1357;

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0; reg_addr = watch;
  endtask

  task automatic look(input logic [3:0] a, input int n);
    @(negedge clk); #1;
    watch = a; reg_addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 act=running exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while still in reset
    chk("R1 ce_n", nand_ce_n, 1);
    chk("R1 we_n", nand_we_n, 1);
    chk("R1 re_n", nand_re_n, 1);
    chk("R1 cle/ale", {nand_cle, nand_ale}, 0);
    chk("R1 dq_oe", nand_dq_oe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 status", reg_rdata, 16'h10);
    #1 rst_n = 1'b1;

    look(4'd0, 2);
    chk("R1 ctrl", reg_rdata, 0);
    look(4'd2, 2);
    chk("R1 flags", reg_rdata, 0);
    // R2 R3 R4 R6 R7: burst that fills the queue and overflows
    look(4'd1, 1);
    wr(4'd0, 16'h0213);
    wr(4'd4, 16'h12A5);
    wr(4'd5, 16'hFF3C);
    wr(4'd5, 16'h007E);
    wr(4'd4, 16'h0030);
    wr(4'd6, 16'hAB55);
    wr(4'd6, 16'h0066);
    wr(4'd6, 16'h0077);
    wr(4'd6, 16'h0088);
    look(4'd1, 70);
    // R10: write 0 leaves flags, write 1 clears one bit
    look(4'd2, 2);
    wr(4'd2, 16'h0000);
    look(4'd2, 2);
    wr(4'd2, 16'h0002);
    look(4'd2, 2);
    wr(4'd2, 16'hFFFF);
    look(4'd2, 2);
    chk("R10 cleared", reg_rdata, 0);
    // R11 R5: reads in narrow then wide mode
    wr(4'd3, 16'h001F);
    look(4'd8, 1);
    wr(4'd7, 16'hDEAD);
    look(4'd8, 10);
    wr(4'd0, 16'h0135);
    wr(4'd7, 16'h0000);
    look(4'd1, 3);
    look(4'd8, 12);
    look(4'd2, 2);
    wr(4'd2, 16'h0008);
    // R4 R8 R13: wide data write, then write-done
    look(4'd1, 1);
    wr(4'd6, 16'hBEEF);
    look(4'd1, 4);
    look(4'd2, 14);
    // R12: control readback
    wr(4'd3, 16'h0010);
    look(4'd0, 1);
    wr(4'd0, 16'hFFFF);
    look(4'd0, 2);
    chk("R12 ctrl upper", reg_rdata, 16'h03FF);
    // R9: ready/busy synchronisation and rising-edge flag
    wr(4'd3, 16'h0001);
    look(4'd1, 1);
    nand_rb = 1'b1;
    look(4'd1, 5);
    nand_rb = 1'b0;
    look(4'd1, 4);
    look(4'd2, 2);
    wr(4'd2, 16'h0001);
    look(4'd1, 1);
    nand_rb = 1'b1;
    look(4'd1, 5);
    look(4'd2, 3);
    finish_run();
  end
endmodule